// File: doc/BRIEF.md
# Hotspot-Driven Two-Wire EEPROM Bit Interface

This block lets processor software clock a two-wire serial EEPROM one bit at a time, purely by touching four adjacent addresses. No data register is read or written: the address of a bus cycle selects the action. The serial clock shares a wire with the A14 memory address line. A clock pulse is one bus cycle in which that line is forced high. The data line is open-drain, so the block only switches a pull-down on or off.

Each bus cycle is marked by three one-clock strobes on the block's fast clock: `phi_start` (the address is valid from here), `phi_mid` (the middle of the cycle) and `phi_end` (the last clock of the cycle). The address and data bit 7 are held for the whole cycle. A four-state cycle tracker (plus idle) is loaded at `phi_start` from the low two address bits and returns to idle at `phi_end`.

States and transitions:
- `ST_IDLE`: no hotspot cycle is in progress. On `phi_start` with a hotspot address it moves to the state for that offset; otherwise it stays.
- `ST_SAMPLE` (offset 0): at `phi_end` it captures SDA into the bank bit, then goes to idle.
- `ST_CLOCK` (offset 1): forces A14 high and returns to idle at `phi_end`.
- `ST_DRIVE` (offset 2): at `phi_mid` it loads the pull-down from data bit 7, then goes to idle at `phi_end`.
- `ST_CLK_TOGGLE` (offset 3): forces A14 high, inverts the pull-down at `phi_mid`, and returns to idle at `phi_end`.

Top module: `hotspot_eeprom_bitbang`

## Requirements
- R1: While reset is held and after it ends with no hotspot cycle, `a14_force_hi` is 0, `sda_pull_low` is 0 (line released) and `bank_a8` is 0.
- R2: A cycle at address HOT_BASE+1 drives `a14_force_hi` to 1 from the clock edge where `phi_start` is sampled through the edge where `phi_end` is sampled. It changes neither `sda_pull_low` nor `bank_a8`.
- R3: A cycle at HOT_BASE+0 sets `bank_a8` at the `phi_end` edge to the SDA level (1 = high), seen through SYNC_STAGES flops. `bank_a8` keeps that value until the next such cycle and changes at no other edge.
- R4: A cycle at HOT_BASE+2 sets `sda_pull_low` at the `phi_mid` edge to the inverse of `cpu_d7` (D7=0 pulls low, D7=1 releases). It does not force A14.
- R5: A cycle at HOT_BASE+3 forces A14 high as in R2 and inverts `sda_pull_low` at the `phi_mid` edge.
- R6: `sda_pull_low` changes only at a `phi_mid` edge of a HOT_BASE+2 or HOT_BASE+3 cycle. Any other address, including neighbours of the window and addresses that differ only in upper bits, leaves all three outputs untouched.
- R7: `a14_force_hi` returns to 0 on the edge after `phi_end`, so the next bus cycle sees normal addressing.
- R8: A sample cycle followed by a clock cycle, repeated eight times with SDA released, returns the EEPROM's byte most significant bit first in `bank_a8`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that carries the bus-cycle strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | Processor address, held for the whole bus cycle |
| cpu_d7 | input | 1 | Processor data bit 7, sampled at mid-cycle |
| phi_start | input | 1 | One-clock strobe at the first clock of a bus cycle |
| phi_mid | input | 1 | One-clock strobe at the middle of a bus cycle |
| phi_end | input | 1 | One-clock strobe at the last clock of a bus cycle |
| sda_in | input | 1 | Level of the open-drain data line |
| a14_force_hi | output | 1 | Forces the shared A14 / serial clock line high |
| sda_pull_low | output | 1 | Enables the pull-down on the data line |
| bank_a8 | output | 1 | Bit 8 of the upper-bank address |

## Verification
The bench builds the block with a 13-bit address, the hotspot window at 0x6C and a two-flop SDA synchronizer, using six-clock bus cycles with the middle strobe on the fourth clock. The 13-bit width leaves room for addresses such as 0x106C that alias the window in their low bits but must be ignored. The two-stage synchronizer combined with a short cycle shows that a level the responder sets after a clock pulse still reaches the bank bit by the end of the next sample cycle. A small responder model shifts a byte out on falling clock pulses, so that full byte reads can be checked.

// File: rtl/hotspot_eeprom_pkg.sv
package hotspot_eeprom_pkg;

    // Action chosen by the two low address bits inside the hotspot window.
    // The offsets are fixed: indexed software pairs rely on them.
    typedef enum logic [1:0] {
        OP_SAMPLE     = 2'd0,
        OP_CLOCK      = 2'd1,
        OP_DRIVE      = 2'd2,
        OP_CLK_TOGGLE = 2'd3
    } hot_op_e;

    // Per-bus-cycle tracker state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CLOCK,
        ST_DRIVE,
        ST_CLK_TOGGLE
    } cyc_state_e;

    function automatic cyc_state_e op_to_state(input hot_op_e op);
        cyc_state_e s;
        unique case (op)
            OP_SAMPLE:     s = ST_SAMPLE;
            OP_CLOCK:      s = ST_CLOCK;
            OP_DRIVE:      s = ST_DRIVE;
            OP_CLK_TOGGLE: s = ST_CLK_TOGGLE;
            default:       s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hotspot_decode.sv
module hotspot_decode
    import hotspot_eeprom_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int HOT_BASE = 'h6C
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              hit,
    output hot_op_e           op
);
    // Window of four addresses aligned on a multiple of four.
    localparam int TAG_W = ADDR_W - 2;
    localparam logic [TAG_W-1:0] HOT_TAG = TAG_W'(HOT_BASE >> 2);

    always_comb begin
        hit = (cpu_addr[ADDR_W-1:2] == HOT_TAG);
        op  = hot_op_e'(cpu_addr[1:0]);
    end

endmodule

// File: rtl/sda_sync.sv
module sda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Idle level of an open-drain line is high, so the chain resets to 1.
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= 1'b1;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '1;
                else        r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/hotspot_cycle_fsm.sv
module hotspot_cycle_fsm
    import hotspot_eeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hit,
    input  hot_op_e op,
    input  logic    cpu_d7,
    input  logic    phi_start,
    input  logic    phi_mid,
    input  logic    phi_end,
    input  logic    sda_level,
    output logic    a14_force_hi,
    output logic    sda_pull_low,
    output logic    bank_a8
);
    cyc_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: load at cycle start, drop back to idle at cycle end.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (phi_start && hit) state_d = op_to_state(op);
            end
            ST_SAMPLE, ST_CLOCK, ST_DRIVE, ST_CLK_TOGGLE: begin
                if (phi_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Clock override is a pure decode of the state, so it spans the cycle.
    assign a14_force_hi = (state_q == ST_CLOCK) || (state_q == ST_CLK_TOGGLE);

    // Held outputs: pull-down updates at mid-cycle, bank bit at cycle end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_low <= 1'b0;
            bank_a8      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DRIVE: begin
                    if (phi_mid) sda_pull_low <= ~cpu_d7;
                end
                ST_CLK_TOGGLE: begin
                    if (phi_mid) sda_pull_low <= ~sda_pull_low;
                end
                ST_SAMPLE: begin
                    if (phi_end) bank_a8 <= sda_level;
                end
                ST_IDLE, ST_CLOCK: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/hotspot_eeprom_bitbang.sv
module hotspot_eeprom_bitbang
    import hotspot_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int HOT_BASE    = 'h6C,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_d7,
    input  logic              phi_start,
    input  logic              phi_mid,
    input  logic              phi_end,
    input  logic              sda_in,
    output logic              a14_force_hi,
    output logic              sda_pull_low,
    output logic              bank_a8
);
    logic    hot_hit;
    hot_op_e hot_op;
    logic    sda_level;

    hotspot_decode #(
        .ADDR_W  (ADDR_W),
        .HOT_BASE(HOT_BASE)
    ) u_decode (
        .cpu_addr(cpu_addr),
        .hit     (hot_hit),
        .op      (hot_op)
    );

    sda_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sda_in),
        .q    (sda_level)
    );

    hotspot_cycle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hot_hit),
        .op          (hot_op),
        .cpu_d7      (cpu_d7),
        .phi_start   (phi_start),
        .phi_mid     (phi_mid),
        .phi_end     (phi_end),
        .sda_level   (sda_level),
        .a14_force_hi(a14_force_hi),
        .sda_pull_low(sda_pull_low),
        .bank_a8     (bank_a8)
    );

endmodule

// File: rtl/hotspot_eeprom_bitbang_chk.sv
module hotspot_eeprom_bitbang_chk #(
    parameter int ADDR_W   = 13,
    parameter int HOT_BASE = 'h6C
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_d7,
    input logic              phi_start,
    input logic              phi_mid,
    input logic              phi_end,
    input logic              a14_force_hi,
    input logic              sda_pull_low,
    input logic              bank_a8
);
    localparam logic [ADDR_W-1:0] A_DRIVE  = ADDR_W'(HOT_BASE + 2);
    localparam logic [ADDR_W-1:0] A_TOGGLE = ADDR_W'(HOT_BASE + 3);

    // R1: outputs are cleared one edge into reset
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!a14_force_hi && !sda_pull_low && !bank_a8));

    // R2: the clock override can only start at a cycle start
    p_a14_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a14_force_hi) |-> $past(phi_start));

    // R3: bank bit moves only at a cycle end
    p_bank_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_a8) |-> $past(phi_end));

    // R4: drive hotspot loads the inverse of D7 at mid-cycle
    p_drive_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phi_mid && cpu_addr == A_DRIVE) |=> (sda_pull_low == !$past(cpu_d7)));

    // R5: toggle hotspot inverts the pull-down at mid-cycle
    p_toggle_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phi_mid && cpu_addr == A_TOGGLE) |=> (sda_pull_low != $past(sda_pull_low)));

    // R6: the pull-down moves only at a mid-cycle edge
    p_pull_mid_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low) |-> $past(phi_mid));

    // R7: the override is gone on the edge after the cycle end
    p_a14_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a14_force_hi && phi_end) |=> !a14_force_hi);

endmodule

bind hotspot_eeprom_bitbang hotspot_eeprom_bitbang_chk #(
    .ADDR_W  (ADDR_W),
    .HOT_BASE(HOT_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_d7      (cpu_d7),
    .phi_start   (phi_start),
    .phi_mid     (phi_mid),
    .phi_end     (phi_end),
    .a14_force_hi(a14_force_hi),
    .sda_pull_low(sda_pull_low),
    .bank_a8     (bank_a8)
);

// File: tb/hotspot_eeprom_bitbang_tb.sv
module hotspot_eeprom_bitbang_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 13;
    localparam int HOT_BASE   = 'h6C;

    localparam logic [ADDR_W-1:0] A_SAMPLE = 13'h006C;
    localparam logic [ADDR_W-1:0] A_CLOCK  = 13'h006D;
    localparam logic [ADDR_W-1:0] A_DRIVE  = 13'h006E;
    localparam logic [ADDR_W-1:0] A_TOGGLE = 13'h006F;
    localparam logic [ADDR_W-1:0] A_RAM    = 13'h0080;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = A_RAM;
    logic              cpu_d7 = 1'b0;
    logic              phi_start = 1'b0;
    logic              phi_mid = 1'b0;
    logic              phi_end = 1'b0;
    logic              sda_in;
    logic              a14_force_hi;
    logic              sda_pull_low;
    logic              bank_a8;

    // EEPROM responder: presents resp_byte MSB first, advancing on each
    // falling clock pulse.
    logic       resp_en = 1'b0;
    logic [7:0] resp_byte = 8'h00;
    logic [2:0] resp_idx = 3'd7;
    logic       resp_pull;

    assign resp_pull = resp_en && !resp_byte[resp_idx];
    assign sda_in    = !(sda_pull_low || resp_pull);

    always @(negedge a14_force_hi) begin
        if (resp_en && resp_idx != 3'd0) resp_idx <= resp_idx - 3'd1;
    end

    int n_tests = 0;
    int n_fail  = 0;

    // Values captured inside the last bus cycle.
    logic cap_a14_in, cap_pull_pre, cap_pull_post, cap_a14_post;

    hotspot_eeprom_bitbang #(
        .ADDR_W     (ADDR_W),
        .HOT_BASE   (HOT_BASE),
        .SYNC_STAGES(2)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (cpu_addr),
        .cpu_d7      (cpu_d7),
        .phi_start   (phi_start),
        .phi_mid     (phi_mid),
        .phi_end     (phi_end),
        .sda_in      (sda_in),
        .a14_force_hi(a14_force_hi),
        .sda_pull_low(sda_pull_low),
        .bank_a8     (bank_a8)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // One six-clock bus cycle: start at clock 0, mid at 3, end at 5.
    task automatic bus_cycle(input logic [ADDR_W-1:0] a, input logic d7);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 2) begin
                cap_a14_in   = a14_force_hi;
                cap_pull_pre = sda_pull_low;
            end
            if (i == 4) cap_pull_post = sda_pull_low;
            cpu_addr  = a;
            cpu_d7    = d7;
            phi_start = (i == 0);
            phi_mid   = (i == 3);
            phi_end   = (i == 5);
        end
        @(negedge clk);
        cap_a14_post = a14_force_hi;
        phi_start = 1'b0;
        phi_mid   = 1'b0;
        phi_end   = 1'b0;
        cpu_addr  = A_RAM;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "a14 in reset", a14_force_hi, 1'b0);
        chk("R1", "pull in reset", sda_pull_low, 1'b0);
        chk("R1", "bank in reset", bank_a8, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "bank after reset", bank_a8, 1'b0);
        chk("R1", "pull after reset", sda_pull_low, 1'b0);
    endtask

    task automatic t_clock_pulse();
        bus_cycle(A_CLOCK, 1'b0);
        chk("R2", "a14 during clock cycle", cap_a14_in, 1'b1);
        chk("R2", "pull untouched", cap_pull_post, 1'b0);
        chk("R2", "bank untouched", bank_a8, 1'b0);
        chk("R7", "a14 after clock cycle", cap_a14_post, 1'b0);
        bus_cycle(A_RAM, 1'b1);
        chk("R7", "a14 in next ordinary cycle", cap_a14_in, 1'b0);
    endtask

    task automatic t_drive();
        bus_cycle(A_DRIVE, 1'b0);
        chk("R4", "pull before mid", cap_pull_pre, 1'b0);
        chk("R4", "pull after mid D7=0", cap_pull_post, 1'b1);
        chk("R4", "no a14 on drive", cap_a14_in, 1'b0);
        bus_cycle(A_DRIVE, 1'b1);
        chk("R4", "pull after mid D7=1", cap_pull_post, 1'b0);
    endtask

    task automatic t_sample();
        bus_cycle(A_DRIVE, 1'b0);
        bus_cycle(A_SAMPLE, 1'b1);
        chk("R3", "bank samples low SDA", bank_a8, 1'b0);
        chk("R3", "no a14 on sample", cap_a14_in, 1'b0);
        bus_cycle(A_DRIVE, 1'b1);
        bus_cycle(A_SAMPLE, 1'b0);
        chk("R3", "bank samples high SDA", bank_a8, 1'b1);
        bus_cycle(A_DRIVE, 1'b0);
        bus_cycle(A_CLOCK, 1'b0);
        bus_cycle(A_RAM, 1'b0);
        chk("R3", "bank held across other cycles", bank_a8, 1'b1);
        bus_cycle(A_DRIVE, 1'b1);
    endtask

    task automatic t_toggle();
        bus_cycle(A_TOGGLE, 1'b1);
        chk("R5", "a14 during toggle", cap_a14_in, 1'b1);
        chk("R5", "pull before mid", cap_pull_pre, 1'b0);
        chk("R5", "pull toggled to on", cap_pull_post, 1'b1);
        chk("R7", "a14 after toggle", cap_a14_post, 1'b0);
        // indexed pair: toggle offset followed by plain clock offset
        bus_cycle(A_CLOCK, 1'b1);
        chk("R2", "clock keeps pull", cap_pull_post, 1'b1);
        bus_cycle(A_TOGGLE, 1'b0);
        chk("R5", "pull toggled to off", cap_pull_post, 1'b0);
    endtask

    task automatic t_ignore();
        logic [ADDR_W-1:0] others [4];
        others[0] = 13'h006B; others[1] = 13'h0070;
        others[2] = 13'h106C; others[3] = 13'h106F;
        bus_cycle(A_DRIVE, 1'b0);
        foreach (others[k]) begin
            bus_cycle(others[k], 1'b1);
            chk("R6", $sformatf("a14 at %h", others[k]), cap_a14_in, 1'b0);
            chk("R6", $sformatf("pull at %h", others[k]), cap_pull_post, 1'b1);
            chk("R6", $sformatf("bank at %h", others[k]), bank_a8, 1'b1);
        end
        bus_cycle(A_DRIVE, 1'b1);
    endtask

    task automatic t_read_byte(input logic [7:0] b);
        resp_byte = b;
        resp_idx  = 3'd7;
        resp_en   = 1'b1;
        bus_cycle(A_DRIVE, 1'b1);
        for (int i = 7; i >= 0; i--) begin
            bus_cycle(A_SAMPLE, 1'b0);
            chk("R8", $sformatf("read bit %0d of %h", i, b), bank_a8, b[i]);
            bus_cycle(A_CLOCK, 1'b0);
        end
        resp_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_clock_pulse();
        t_drive();
        t_sample();
        t_toggle();
        t_ignore();
        t_read_byte(8'hA5);
        t_read_byte(8'h3C);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule